// File: doc/BRIEF.md
# Memory self-test fill controller

This block sweeps a byte-wide buffer memory of 8192 locations, writing a generated test pattern into every address in order, and folds the written bytes into a 16-bit checksum. Software sets it up through a two-register byte interface. One register holds an 8-bit seed. The other is a control byte that picks the fill mode, the rotate amount and the port assignment, and also carries the enable and start bits. While the sweep runs, the control byte reports busy. When the last location is written, busy clears by itself and the checksum appears as a high byte and a low byte.

Three fill modes are offered. The first writes pseudo-random bytes from an LFSR seeded by the seed register. The second writes the low byte of each address. The third writes the seed and then rotates it left by a programmable amount after each write. The buffer has two synchronous single-port request ports. A normal DMA requester shares them with the self-test engine, and a swap bit exchanges which requester drives which port.

The memory write stream is a valid-only stream: the write enable is the valid, and there is no ready. A synchronous SRAM accepts one write on every clock, so the engine never stalls. Back-pressure is not possible, and a sweep always takes exactly one clock per location.

Top module: `memfill_bist`

## Requirements
- R1: After reset, the control readback is 0x00, both checksum bytes are 0x00, and neither memory port has its write enable set while the DMA write enable is low.
- R2: The control byte layout is as follows. Bits 2:0 hold the rotate amount, bit 3 is the port swap and bits 5:4 are the fill mode (00 random, 01 address, 10 rotate, 11 reserved). Bit 6 is the enable and bit 7 is start/busy. A control write with bits 7 and 6 set and a mode other than 11 starts a sweep. Starting at the next clock, the engine writes addresses 0 through 8191, one per clock, and busy reads 1 for exactly 8192 clocks before clearing by itself.
- R3: In random mode, the byte written at location k is the LFSR state after k steps from the seed. Each step is next = {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R4: In random mode, a seed of 0x00 is replaced by 0x01.
- R5: In address mode, every location receives the low byte of its own address.
- R6: In rotate mode, location 0 receives the seed, and each following byte is the previous byte rotated left by the rotate amount. The rotate amount has no effect in the other modes.
- R7: The checksum has three properties:
  - It is the ones-complement of the ones-complement sum of 16-bit words formed from the bytes at addresses 2i (high byte) and 2i+1 (low byte).
  - It is loaded into the checksum bytes when the sweep ends.
  - It stays unchanged while a sweep runs.
- R8: A start request is ignored, and busy stays 0, when the mode field is 11 or the enable bit is 0.
- R9: Control writes made while busy do not change the control fields or the running sweep.
- R10: With swap at 0, the DMA requester drives port 0 and the self-test engine drives port 1. With swap at 1, these are exchanged. The self-test engine's port has its write enable low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 seed |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control readback with busy in bit 7 |
| cks_hi | output | 8 | Checksum high byte |
| cks_lo | output | 8 | Checksum low byte |
| dma_addr | input | 13 | DMA requester address |
| dma_wdata | input | 8 | DMA requester write data |
| dma_we | input | 1 | DMA requester write enable |
| p0_addr | output | 13 | Memory port 0 address |
| p0_wdata | output | 8 | Memory port 0 write data |
| p0_we | output | 1 | Memory port 0 write enable |
| p1_addr | output | 13 | Memory port 1 address |
| p1_wdata | output | 8 | Memory port 1 write data |
| p1_we | output | 1 | Memory port 1 write enable |

## Verification
The fill is tried with several seeds and modes:
- Random mode with a seed of 0xA5 shows that the LFSR steps correctly.
- A zero seed shows that the substitute seed is used.
- Address mode, run with a nonzero rotate amount, shows that the data comes from the address and that the rotate amount is ignored.
- Rotate mode is run with amounts 3, 0 and 1. Amount 0 must produce a constant fill, and amount 3 must walk every rotation.

Each sweep is compared byte by byte and address by address against a model, together with its checksum. The swapped runs show that the engine has moved to port 0. One of them receives a control write in mid-sweep, which must be discarded. Reserved-mode and disabled starts are tried from idle, and both must leave busy low.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
  typedef enum logic [1:0] {
    FILL_RAND  = 2'b00,
    FILL_ADDR  = 2'b01,
    FILL_ROT   = 2'b10,
    FILL_RSVD  = 2'b11
  } fill_mode_e;

  function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input logic [2:0] n);
    logic [15:0] dbl;
    dbl = {v, v} << n;
    return dbl[15:8];
  endfunction

  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction
endpackage

// File: rtl/memfill_patgen.sv
module memfill_patgen
  import memfill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  fill_mode_e load_mode,
  input  logic [7:0] seed,
  input  logic       adv,
  input  fill_mode_e run_mode,
  input  logic [2:0] rot_amt,
  input  logic [7:0] addr_lo,
  output logic [7:0] data
);
  logic [7:0] pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q <= 8'h00;
    end else if (load) begin
      if (load_mode == FILL_RAND && seed == 8'h00) pat_q <= 8'h01;
      else                                         pat_q <= seed;
    end else if (adv) begin
      case (run_mode)
        FILL_RAND: pat_q <= lfsr8_next(pat_q);
        FILL_ROT:  pat_q <= rotl8(pat_q, rot_amt);
        default:   pat_q <= pat_q;
      endcase
    end
  end

  assign data = (run_mode == FILL_ADDR) ? addr_lo : pat_q;
endmodule

// File: rtl/memfill_cksum.sv
module memfill_cksum
  import memfill_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr,
  input  logic        odd,
  input  logic        last,
  input  logic [7:0]  data,
  output logic [15:0] result
);
  logic [7:0]  hi_q;
  logic [15:0] acc_q;
  logic [15:0] acc_nxt;

  assign acc_nxt = oc_add16(acc_q, {hi_q, data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= 8'h00;
      acc_q  <= 16'h0000;
      result <= 16'h0000;
    end else if (clr) begin
      hi_q  <= 8'h00;
      acc_q <= 16'h0000;
    end else if (wr) begin
      if (!odd) hi_q  <= data;
      else      acc_q <= acc_nxt;
      if (last) result <= ~acc_nxt;
    end
  end
endmodule

// File: rtl/memfill_portsel.sv
module memfill_portsel #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              swap,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_we,
  output logic [ADDR_W-1:0] port_addr  [2],
  output logic [DATA_W-1:0] port_wdata [2],
  output logic              port_we    [2]
);
  for (genvar i = 0; i < 2; i++) begin : g_port
    logic to_engine;
    assign to_engine     = (i == 1) ^ swap;
    assign port_addr[i]  = to_engine ? eng_addr  : dma_addr;
    assign port_wdata[i] = to_engine ? eng_wdata : dma_wdata;
    assign port_we[i]    = to_engine ? eng_we    : dma_we;
  end
endmodule

// File: rtl/memfill_bist.sv
module memfill_bist
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_rdata,
  output logic [7:0]        cks_hi,
  output logic [7:0]        cks_lo,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [7:0]        dma_wdata,
  input  logic              dma_we,
  output logic [ADDR_W-1:0] p0_addr,
  output logic [7:0]        p0_wdata,
  output logic              p0_we,
  output logic [ADDR_W-1:0] p1_addr,
  output logic [7:0]        p1_wdata,
  output logic              p1_we
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [2:0]        rot_q;
  logic              swap_q;
  fill_mode_e        mode_q;
  logic              en_q;
  logic              busy_q;
  logic [7:0]        seed_q;
  logic [ADDR_W-1:0] addr_q;

  logic       ctrl_wr, start_ok, last_wr;
  fill_mode_e wr_mode;
  logic [7:0] eng_data;
  logic [15:0] cks;

  assign ctrl_wr  = reg_wr && !reg_sel && !busy_q;
  assign wr_mode  = fill_mode_e'(reg_wdata[5:4]);
  assign start_ok = ctrl_wr && reg_wdata[7] && reg_wdata[6] && (wr_mode != FILL_RSVD);
  assign last_wr  = busy_q && (addr_q == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_q  <= 3'd0;
      swap_q <= 1'b0;
      mode_q <= FILL_RAND;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      seed_q <= 8'h00;
      addr_q <= '0;
    end else begin
      if (ctrl_wr) begin
        rot_q  <= reg_wdata[2:0];
        swap_q <= reg_wdata[3];
        mode_q <= wr_mode;
        en_q   <= reg_wdata[6];
      end
      if (reg_wr && reg_sel && !busy_q) seed_q <= reg_wdata;
      if (start_ok) begin
        busy_q <= 1'b1;
        addr_q <= '0;
      end else if (busy_q) begin
        addr_q <= addr_q + 1'b1;
        if (last_wr) busy_q <= 1'b0;
      end
    end
  end

  memfill_patgen u_pat (
    .clk(clk), .rst_n(rst_n),
    .load(start_ok), .load_mode(wr_mode), .seed(seed_q),
    .adv(busy_q), .run_mode(mode_q), .rot_amt(rot_q),
    .addr_lo(addr_q[7:0]), .data(eng_data)
  );

  memfill_cksum u_cks (
    .clk(clk), .rst_n(rst_n),
    .clr(start_ok), .wr(busy_q), .odd(addr_q[0]), .last(last_wr),
    .data(eng_data), .result(cks)
  );

  logic [ADDR_W-1:0] pa [2];
  logic [7:0]        pd [2];
  logic              pw [2];

  memfill_portsel #(.ADDR_W(ADDR_W), .DATA_W(8)) u_psel (
    .swap(swap_q),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_we(dma_we),
    .eng_addr(addr_q), .eng_wdata(eng_data), .eng_we(busy_q),
    .port_addr(pa), .port_wdata(pd), .port_we(pw)
  );

  assign p0_addr = pa[0]; assign p0_wdata = pd[0]; assign p0_we = pw[0];
  assign p1_addr = pa[1]; assign p1_wdata = pd[1]; assign p1_we = pw[1];

  assign ctrl_rdata = {busy_q, en_q, mode_q, swap_q, rot_q};
  assign cks_hi = cks[15:8];
  assign cks_lo = cks[7:0];
endmodule

// File: rtl/memfill_bist_chk.sv
module memfill_bist_chk
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        eng_data,
  input fill_mode_e        mode,
  input logic [7:0]        ctrl_rdata,
  input logic [7:0]        cks_hi,
  input logic [7:0]        cks_lo,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [1:0]        wr_mode
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [ADDR_W:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_cnt <= '0;
    else                 run_cnt <= run_cnt + 1'b1;
  end

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == (ADDR_W+1)'(DEPTH));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> addr == ADDR_W'($past(addr) + 1'b1));

  assert_addr_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode == FILL_ADDR |-> eng_data == addr[7:0]);

  assert_cks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable({cks_hi, cks_lo}));

  assert_bad_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_sel && !busy && wr_mode == 2'b11 |=> !busy);

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ctrl_rdata));
endmodule

bind memfill_bist memfill_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .addr(addr_q), .eng_data(eng_data),
  .mode(mode_q), .ctrl_rdata(ctrl_rdata), .cks_hi(cks_hi), .cks_lo(cks_lo),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_mode(reg_wdata[5:4])
);

// File: tb/memfill_bist_tb.sv
`timescale 1ns/1ps
module memfill_bist_tb;
  localparam int ADDR_W = 13;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] ctrl_rdata, cks_hi, cks_lo;
  logic [ADDR_W-1:0] dma_addr = '0;
  logic [7:0] dma_wdata = 8'h00;
  logic dma_we = 1'b0;
  logic [ADDR_W-1:0] p0_addr, p1_addr;
  logic [7:0] p0_wdata, p1_wdata;
  logic p0_we, p1_we;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  memfill_bist #(.ADDR_W(ADDR_W)) u_dut (.*);

  // {inject[15], swap[14], mode[13:12], rot[10:8], seed[7:0]}
  localparam logic [15:0] VEC [6] = '{
    16'h00A5,  // R3 random, seed A5
    16'h0500,  // R4 random, zero seed, rot 5 ignored
    16'h175A,  // R5/R6 address mode, rot 7 ignored
    16'h2381,  // R6 rotate by 3
    16'hE03C,  // R6/R9/R10 rotate 0, swapped, mid-run write
    16'h6101   // R6/R10 rotate 1, swapped
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] step_lfsr(input logic [7:0] s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return (s << 1) | {7'd0, fb};
  endfunction

  task automatic run_vec(input logic [15:0] v);
    logic       inj  = v[15];
    logic       swp  = v[14];
    logic [1:0] md   = v[13:12];
    logic [2:0] rot  = v[10:8];
    logic [7:0] seed = v[7:0];
    logic [7:0] ctl, pat, prev, exp_b, got_b;
    logic [ADDR_W-1:0] got_a;
    logic got_w;
    int unsigned sum = 0;
    int bad = 0;
    logic [15:0] exp_ck;
    ctl = {2'b11, md, swp, rot};
    wr_reg(1'b1, seed);
    wr_reg(1'b0, ctl);
    pat = (md == 2'b00 && seed == 8'h00) ? 8'h01 : seed;
    prev = 8'h00;
    for (int k = 0; k < DEPTH; k++) begin
      exp_b = (md == 2'b01) ? k[7:0] : pat;
      got_a = swp ? p0_addr  : p1_addr;
      got_b = swp ? p0_wdata : p1_wdata;
      got_w = swp ? p0_we    : p1_we;
      if (bad == 0 && !(got_w && got_a == k[ADDR_W-1:0] && got_b == exp_b)) begin
        bad = 1;
        $display("FAIL R2/R3/R5/R6 stream k=%0d actual=%0h/%0h/%0h expected=1/%0h/%0h",
                 k, got_w, got_a, got_b, k, exp_b);
      end
      if (k[0]) sum += {16'd0, prev, exp_b};
      prev = exp_b;
      if (md == 2'b00) pat = step_lfsr(pat);
      else if (md == 2'b10) pat = 8'((16'(pat) << rot) | (16'(pat) >> (8 - rot)));
      if (inj && k == 100) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hC5;
      end
      if (inj && k == 101) reg_wr = 1'b0;
      @(negedge clk);
    end
    n_chk++;
    if (bad != 0) n_fail++;
    while ((sum >> 16) != 0) sum = (sum & 32'hFFFF) + (sum >> 16);
    exp_ck = ~sum[15:0];
    check(ctrl_rdata[7] == 1'b0, "R2 busy self-clear", ctrl_rdata, 0);
    check({cks_hi, cks_lo} == exp_ck, "R7 checksum", {cks_hi, cks_lo}, exp_ck);
    if (inj) check(ctrl_rdata == {1'b0, ctl[6:0]}, "R9 ctrl hold", ctrl_rdata, {1'b0, ctl[6:0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 0);
    check({cks_hi, cks_lo} == 16'h0, "R1 cks", {cks_hi, cks_lo}, 0);
    check(!p0_we && !p1_we, "R1 we", {p0_we, p1_we}, 0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R8 reserved mode start ignored
    wr_reg(1'b0, 8'hF0);
    check(ctrl_rdata[7] == 1'b0 && !p1_we, "R8 reserved", ctrl_rdata, 8'h70);
    @(negedge clk);
    check(ctrl_rdata == 8'h70 && !p1_we, "R8 reserved hold", ctrl_rdata, 8'h70);
    // R8 enable clear
    wr_reg(1'b0, 8'h80);
    check(ctrl_rdata == 8'h00 && !p1_we, "R8 disabled", ctrl_rdata, 0);

    // R10 normal: DMA on port 0, engine port idle
    dma_addr = 13'h1ABC; dma_wdata = 8'h5E; dma_we = 1'b1;
    @(negedge clk);
    check(p0_addr == 13'h1ABC && p0_wdata == 8'h5E && p0_we && !p1_we,
          "R10 normal", {p0_we, p1_we}, 2'b10);
    // R10 swapped without start
    wr_reg(1'b0, 8'h48);
    check(p1_addr == 13'h1ABC && p1_wdata == 8'h5E && p1_we && !p0_we,
          "R10 swapped", {p0_we, p1_we}, 2'b01);
    dma_we = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule